// File: doc/BRIEF.md
# Multiword DMA host controller

This block is the host side of a parallel ATA multiword DMA transfer on a 16-bit data bus. Software-facing logic programs a direction, a timing mode (0, 1 or 2) and a word count, then pulses `start`. The controller waits for the device's DMA request, raises the acknowledge and issues read or write strobe pulses. Each pulse moves one 16-bit word between the bus and a simple host-side word stream. On the write side, a word is taken from `wr_data` with `wr_take`. On the read side, each word is presented on `rd_data` with a one-cycle `rd_valid`.

The device may end a burst by dropping its request during a pulse. The controller then finishes that pulse, releases the acknowledge, and starts a new burst when the request returns, as long as words remain. The host may end the transfer with `abort`, which takes effect at the next pulse boundary. `done` rises when the programmed count has been moved.

All bus timing is counted in clock cycles derived from the clock period parameter. The device request passes through a two-flop synchronizer before any decision is made on it.

Top module: `mwdma_host`

## Requirements
- R1: `host_ack` rises only after the synchronized device request has been seen high while a transfer is pending. It stays low for as long as `dev_req` stays low after `start`.
- R2: While `host_ack` is high, `cs_n` is 2'b11 (both chip selects negated). While `host_ack` is low, `cs_n` is 2'b00.
- R3: Strobe timing is set by the mode. Mode 3 is treated as mode 2.
  - Each strobe pulse is at least 215/80/70 ns wide for modes 0/1/2.
  - Within a burst, pulse start to pulse start is at least 480/150/120 ns.
  - The negated time between pulses is at least 50/50/25 ns for reads and 215/50/25 ns for writes.
- R4: On a write (`dir_read`=0), `bus_oe` is high for the whole burst. `bus_dout` carries the word taken from `wr_data` in the `wr_take` cycle that starts each pulse, words in order, and stays valid at strobe negation.
- R5: On a read (`dir_read`=1), the word on `bus_din` at the last cycle of each pulse is presented on `rd_data` with a one-cycle `rd_valid`, words in order.
- R6: If the device drops its request during a pulse, that pulse is the last one of the burst and `host_ack` is released. When the request returns and words remain, a new burst resumes the transfer.
- R7: A strobe is high only while `host_ack` is high, and `host_ack` is high for at least one cycle before a strobe rises. After the last strobe of a burst falls, `host_ack` stays high for at least 20/5/5 ns (reads) or 20/15/10 ns (writes).
- R8: A transfer makes exactly `word_count` strobe pulses in total. `done` then goes high with `host_ack` low and `busy` low, and holds until the next `start`.
- R9: An `abort` during a transfer lets the current pulse complete. It then ends the transfer with no further pulse: `host_ack` and `busy` fall and `done` stays low.
- R10: A `start` with `word_count` = 0 raises `done` on the next cycle without raising `host_ack` or `busy`.
- R11: Only `rd_strobe` pulses on reads and only `wr_strobe` pulses on writes; the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| dir_read | input | 1 | 1 = device to host, 0 = host to device |
| xfer_mode | input | 2 | Timing mode 0..2 (3 acts as 2) |
| word_count | input | CW | Number of 16-bit words to move |
| abort | input | 1 | Host termination request |
| wr_data | input | DW | Next word to write |
| wr_take | output | 1 | `wr_data` is consumed this cycle |
| rd_data | output | DW | Word read from the bus |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Word count exhausted |
| dev_req | input | 1 | Device DMA request (asynchronous) |
| host_ack | output | 1 | DMA acknowledge to the device |
| cs_n | output | 2 | Chip selects, active low |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| bus_dout | output | DW | Data driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_din | input | DW | Data from the bus |

## Verification
The hardest case to produce is a device-ended burst in which the request drops inside one particular pulse. The word count must still be spread correctly over the following bursts. A bench device model handles this: it counts rising strobes and drops its request on the rising edge of the pulse it has chosen, then raises it again a few cycles after the acknowledge is released. A second hard case is a host abort that lands inside a pulse. The bench waits until it has seen the third pulse rise, then pulses `abort` while that pulse is still high, and expects exactly three words in total.

// File: rtl/mwdma_host.sv
module mwdma_host #(
  parameter int CLK_NS = 10,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_read,
  input  logic [1:0]    xfer_mode,
  input  logic [CW-1:0] word_count,
  input  logic          abort,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          done,
  input  logic          dev_req,
  output logic          host_ack,
  output logic [1:0]    cs_n,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AS0 = cyc(215);
  localparam int AS1 = cyc(80);
  localparam int AS2 = cyc(70);
  localparam int RR0 = maxi(maxi(cyc(50), cyc(480) - AS0), cyc(20));
  localparam int RR1 = maxi(maxi(cyc(50), cyc(150) - AS1), cyc(15));
  localparam int RR2 = maxi(maxi(cyc(25), cyc(120) - AS2), cyc(10));
  localparam int RW0 = maxi(maxi(cyc(215), cyc(480) - AS0), cyc(20));
  localparam int RW1 = maxi(maxi(cyc(50), cyc(150) - AS1), cyc(15));
  localparam int RW2 = maxi(maxi(cyc(25), cyc(120) - AS2), cyc(10));
  localparam int TW = $clog2(cyc(480) + cyc(215) + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SETUP, S_STRB, S_RECOV} st_t;

  st_t           state;
  logic [1:0]    mode_q;
  logic          dir_q;
  logic [CW-1:0] remain;
  logic [TW-1:0] tmr;
  logic          rq_m, rq_s;
  logic          stop_dev, stop_host;
  logic [DW-1:0] dout_q;
  logic [TW-1:0] a_len, r_len;
  logic          tmr_zero, cont, enter_strb;

  always_comb begin
    case (mode_q)
      2'd0: begin
        a_len = TW'(AS0 - 1);
        r_len = dir_q ? TW'(RR0 - 1) : TW'(RW0 - 1);
      end
      2'd1: begin
        a_len = TW'(AS1 - 1);
        r_len = dir_q ? TW'(RR1 - 1) : TW'(RW1 - 1);
      end
      default: begin
        a_len = TW'(AS2 - 1);
        r_len = dir_q ? TW'(RR2 - 1) : TW'(RW2 - 1);
      end
    endcase
  end

  assign tmr_zero   = (tmr == '0);
  assign cont       = rq_s & ~stop_dev & ~stop_host & ~abort & (remain != '0);
  assign enter_strb = (state == S_SETUP) | ((state == S_RECOV) & tmr_zero & cont);

  assign host_ack  = (state == S_SETUP) | (state == S_STRB) | (state == S_RECOV);
  assign cs_n      = {2{host_ack}};
  assign rd_strobe = (state == S_STRB) & dir_q;
  assign wr_strobe = (state == S_STRB) & ~dir_q;
  assign bus_oe    = host_ack & ~dir_q;
  assign bus_dout  = dout_q;
  assign wr_take   = enter_strb & ~dir_q;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_m <= 1'b0;
      rq_s <= 1'b0;
    end else begin
      rq_m <= dev_req;
      rq_s <= rq_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mode_q    <= 2'd0;
      dir_q     <= 1'b0;
      remain    <= '0;
      tmr       <= '0;
      stop_dev  <= 1'b0;
      stop_host <= 1'b0;
      dout_q    <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (abort && state != S_IDLE) stop_host <= 1'b1;
      if ((state == S_STRB || state == S_RECOV) && !rq_s) stop_dev <= 1'b1;
      if (enter_strb) begin
        tmr <= a_len;
        if (!dir_q) dout_q <= wr_data;
      end
      case (state)
        S_IDLE: begin
          if (start) begin
            if (word_count == '0) begin
              done <= 1'b1;
            end else begin
              done      <= 1'b0;
              remain    <= word_count;
              mode_q    <= (xfer_mode == 2'd3) ? 2'd2 : xfer_mode;
              dir_q     <= dir_read;
              stop_host <= 1'b0;
              state     <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (abort || stop_host) state <= S_IDLE;
          else if (rq_s) state <= S_SETUP;
        end
        S_SETUP: begin
          stop_dev <= 1'b0;
          state    <= S_STRB;
        end
        S_STRB: begin
          if (tmr_zero) begin
            state  <= S_RECOV;
            tmr    <= r_len;
            remain <= remain - 1'b1;
            if (dir_q) begin
              rd_data  <= bus_din;
              rd_valid <= 1'b1;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_RECOV: begin
          if (!tmr_zero) begin
            tmr <= tmr - 1'b1;
          end else if (cont) begin
            state <= S_STRB;
          end else if (remain == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (stop_host || abort) begin
            state <= S_IDLE;
          end else begin
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwdma_host_chk.sv
module mwdma_host_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic rds,
  input logic wrs,
  input logic oe,
  input logic done,
  input logic busy,
  input logic rq_sync
);
  a_r1_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(rq_sync));
  a_r7_strobe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rds || wrs) |-> ack);
  a_r7_ack_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rds || wrs) |-> $past(ack));
  a_r7_ack_held_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rds || wrs) |-> ack);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rds && wrs));
  a_r4_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrs |-> oe);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ack && !busy));
  a_r8_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rds || wrs));
endmodule

bind mwdma_host mwdma_host_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ack(host_ack), .rds(rd_strobe), .wrs(wr_strobe),
  .oe(bus_oe), .done(done), .busy(busy), .rq_sync(rq_s)
);

// File: tb/mwdma_host_tb.sv
module mwdma_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {mode[18:17], read[16], count[15:8], device burst length[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {2'd2, 1'b0, 8'd5, 8'd99},
    {2'd2, 1'b1, 8'd6, 8'd2},
    {2'd1, 1'b0, 8'd7, 8'd3},
    {2'd0, 1'b1, 8'd3, 8'd99},
    {2'd0, 1'b0, 8'd4, 8'd1},
    {2'd3, 1'b1, 8'd5, 8'd4}
  };

  logic clk = 0, rst_n = 0, start = 0, dir_read = 0, abort = 0;
  logic [1:0] xfer_mode = 0;
  logic [15:0] word_count = 0;
  logic [15:0] wr_data, rd_data, bus_dout, bus_din;
  logic wr_take, rd_valid, busy, done, host_ack, rd_strobe, wr_strobe, bus_oe;
  logic dev_req;
  logic [1:0] cs_n;

  int total = 0, bad = 0;
  int hidx = 0;
  int cur_mode = 0; bit cur_rd = 0;
  bit dev_arm = 0; int dev_burst = 1; int dev_end = 0;

  // monitor state (driven only by the monitor block)
  int pulses = 0, bursts = 0, tviol = 0, hviol = 0, dmis = 0, bviol = 0;
  int aviol = 0, csviol = 0, r1viol = 0, sviol = 0;
  int hi = 0, lo = 0, hi_last = 0, hold = 0, bpul = 0, gap = 0;
  int didx = 0, ridx = 0, wdidx = 0;
  bit s_prev = 0, ack_prev = 0, arm_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwdma_host dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read), .xfer_mode(xfer_mode),
    .word_count(word_count), .abort(abort), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .dev_req(dev_req),
    .host_ack(host_ack), .cs_n(cs_n), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'hA5C3 ^ 16'(i * 311);
  endfunction
  function automatic int as_ns(input int m);
    return (m == 0) ? 215 : (m == 1) ? 80 : 70;
  endfunction
  function automatic int cy_ns(input int m);
    return (m == 0) ? 480 : (m == 1) ? 150 : 120;
  endfunction
  function automatic int ng_ns(input int m, input bit rd);
    if (m == 0) return rd ? 50 : 215;
    return (m == 1) ? 50 : 25;
  endfunction
  function automatic int hd_ns(input int m, input bit rd);
    if (m == 0) return 20;
    if (rd) return 5;
    return (m == 1) ? 15 : 10;
  endfunction

  assign wr_data = pat(hidx);
  always @(posedge clk) if (wr_take) hidx <= hidx + 1;

  // device model and bus monitor
  initial begin dev_req = 0; bus_din = 0; end
  always @(negedge clk) begin
    automatic bit s = rd_strobe | wr_strobe;
    if (s && !host_ack) aviol++;
    if (cs_n !== {2{host_ack}}) csviol++;
    if ((rd_strobe && !cur_rd) || (wr_strobe && cur_rd)) sviol++;
    if (host_ack && !ack_prev) begin
      bursts++; bpul = 0;
      if (!dev_req) r1viol++;
    end
    if (s && !s_prev) begin
      if (!ack_prev) aviol++;
      if (bpul > 0) begin
        if (lo * CLK_PERIOD < ng_ns(cur_mode, cur_rd)) tviol++;
        if ((hi_last + lo) * CLK_PERIOD < cy_ns(cur_mode)) tviol++;
      end
      bpul++; pulses++; hi = 0;
      if (rd_strobe) begin bus_din = pat(didx); didx++; end
      if (dev_arm && (bpul == dev_burst || pulses >= dev_end)) dev_req = 0;
    end
    if (s) hi++;
    if (!s && s_prev) begin
      if (hi * CLK_PERIOD < as_ns(cur_mode)) tviol++;
      hi_last = hi; lo = 0; hold = 0;
      if (!cur_rd) begin
        if (!bus_oe || bus_dout !== pat(wdidx)) dmis++;
        wdidx++;
      end
    end
    if (!s) begin lo++; hold++; end
    if (!host_ack && ack_prev) begin
      if ((hold - 1) * CLK_PERIOD < hd_ns(cur_mode, cur_rd)) hviol++;
      if (bpul > dev_burst) bviol++;
      if (dev_arm && pulses < dev_end) gap = 4;
    end
    if (rd_valid) begin
      if (rd_data !== pat(ridx)) dmis++;
      ridx++;
    end
    if (!dev_arm) begin dev_req = 0; gap = 0; end
    else if (!arm_prev) dev_req = 1;
    else if (gap > 0) begin gap--; if (gap == 0) dev_req = 1; end
    s_prev = s; ack_prev = host_ack; arm_prev = dev_arm;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
    chk(!busy, "R8 transfer finishes", busy, 0);
  endtask

  task automatic launch(input int m, input bit rd, input int cnt, input int bur, input bit arm);
    @(negedge clk);
    cur_mode = (m == 3) ? 2 : m; cur_rd = rd;
    dev_burst = bur; dev_end = pulses + cnt;
    xfer_mode = 2'(m); dir_read = rd; word_count = 16'(cnt);
    start = 1;
    @(negedge clk);
    start = 0;
    dev_arm = arm;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, b0, t0, h0, d0, bv0;
    repeat (3) @(negedge clk);
    // reset state
    chk(host_ack == 0, "R7 reset ack", host_ack, 0);
    chk((rd_strobe | wr_strobe) == 0, "R11 reset strobes", rd_strobe | wr_strobe, 0);
    chk(busy == 0 && done == 0, "R8 reset busy/done", {busy, done}, 0);
    chk(cs_n == 2'b00 && bus_oe == 0, "R2 reset cs_n/oe", {cs_n, bus_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic int m = int'(VEC[i][18:17]);
      automatic bit rd = VEC[i][16];
      automatic int cnt = int'(VEC[i][15:8]);
      automatic int bur = int'(VEC[i][7:0]);
      p0 = pulses; b0 = bursts; t0 = tviol; h0 = hviol; d0 = dmis; bv0 = bviol;
      launch(m, rd, cnt, bur, 1);
      wait_idle(20000);
      @(negedge clk);
      dev_arm = 0;
      chk(pulses - p0 == cnt, "R8 pulse count", pulses - p0, cnt);
      chk(bursts - b0 == (cnt + bur - 1) / bur, "R6 burst count", bursts - b0, (cnt + bur - 1) / bur);
      chk(bviol == bv0, "R6 burst ends at dropped request", bviol - bv0, 0);
      chk(tviol == t0, "R3 strobe timing", tviol - t0, 0);
      chk(hviol == h0, "R7 ack hold after strobe", hviol - h0, 0);
      chk(dmis == d0, rd ? "R5 read data" : "R4 write data", dmis - d0, 0);
      chk(done == 1 && host_ack == 0, "R8 done level", {done, host_ack}, 2);
      repeat (10) @(negedge clk);
    end

    // R1: no acknowledge while request stays low
    p0 = pulses;
    launch(1, 1'b1, 3, 99, 0);
    repeat (30) @(negedge clk);
    chk(host_ack == 0 && busy == 1, "R1 ack held off without request", {host_ack, busy}, 1);
    chk(done == 0, "R8 done cleared by start", done, 0);
    dev_arm = 1;
    repeat (6) @(negedge clk);
    chk(host_ack == 1, "R1 ack after request", host_ack, 1);
    chk(cs_n == 2'b11, "R2 chip selects negated under ack", cs_n, 3);
    wait_idle(20000);
    @(negedge clk);
    dev_arm = 0;
    chk(pulses - p0 == 3 && done == 1, "R8 count after delayed request", pulses - p0, 3);
    chk(cs_n == 2'b00, "R2 chip selects after ack", cs_n, 0);

    // R9: abort during the third pulse
    p0 = pulses; d0 = dmis;
    launch(1, 1'b0, 20, 99, 1);
    while (pulses - p0 < 3) @(posedge clk);
    @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    wait_idle(5000);
    @(negedge clk);
    dev_arm = 0;
    chk(pulses - p0 == 3, "R9 pulses after abort", pulses - p0, 3);
    chk(done == 0 && host_ack == 0, "R9 no done after abort", {done, host_ack}, 0);
    chk(dmis == d0, "R4 write data before abort", dmis - d0, 0);
    repeat (20) @(negedge clk);
    chk(pulses - p0 == 3 && busy == 0, "R9 stays stopped", pulses - p0, 3);

    // R10: zero word count
    p0 = pulses;
    launch(2, 1'b0, 0, 99, 0);
    chk(done == 1 && busy == 0 && host_ack == 0, "R10 zero count done", {done, busy, host_ack}, 4);
    repeat (5) @(negedge clk);
    chk(pulses == p0, "R10 no pulses", pulses - p0, 0);

    chk(r1viol == 0, "R1 ack only with request", r1viol, 0);
    chk(aviol == 0, "R7 strobe only under ack", aviol, 0);
    chk(csviol == 0, "R2 chip select tracking", csviol, 0);
    chk(sviol == 0, "R11 strobe matches direction", sviol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule